// File: doc/BRIEF.md
# Heartbeat-Qualified Stage Supervisor

This block is the digital supervisor of one monitor stage in a daisy-chained stack. Each stage is switched on by a heartbeat: a square-wave enable clock whose period must fall inside a window that corresponds to 2 kHz to 40 kHz. The supervisor measures that period in system-clock cycles. It enables the stage after a run of good periods and drops back to idle after repeated bad periods or a silent input. While enabled, it passes the heartbeat on to the next stage down.

The next stage down sends a status clock back. The supervisor checks that this returned clock has the same period as the heartbeat it forwarded. It then drives a complementary status pair that echoes the heartbeat in phase, but only while the stage is enabled, the returned clock matches, and the three measurement fault flags (cell undervoltage, cell overvoltage, low temperature) are clear. The flags are taken at the end-of-measurement strobe, and the status clock may switch on or off only at that strobe. The one exception is entry into idle, which silences the status at once. With a single stage, the heartbeat output is wired straight back to the status input.

Top module: `hb_chain_stage`

## Requirements
- R1: During and straight after reset, `hb_out` and `stat_out` are 0, `stat_out_n` is 1 and `idle` is 1.
- R2: `idle` falls only after three consecutive `hb_in` rising-edge-to-rising-edge periods of between PMIN and PMAX system clocks inclusive. Two such periods are not enough.
- R3: Once enabled, a single period outside the window leaves the stage enabled. Two consecutive out-of-window periods (for example periods shorter than PMIN) set `idle`.
- R4: If no `hb_in` rising edge arrives for more than PMAX system clocks, `idle` is set. A heartbeat slower than the window therefore never enables the stage.
- R5: While enabled, `hb_out` equals `hb_in` delayed by exactly three system-clock cycles. While idle it is held at 0.
- R6: The returned clock matches when two consecutive `ret_in` periods each differ from the last good heartbeat period by no more than that period shifted right by three bits (for 40 this is ±5, so 44 matches and 46 does not). Without a match the status is held off while `idle` stays 0.
- R7: When healthy, `stat_out` equals `hb_out` cycle for cycle. The status switches between echoing and held-low only on a cycle that follows a `meas_done` pulse.
- R8: The fault flags are sampled only on `meas_done` cycles. A flag raised and cleared between strobes has no effect on the status.
- R9: Any one of `uv_flag`, `ov_flag` or `tlow_flag` present at a strobe turns the status off (`stat_out` 0). A later strobe with all flags clear turns it back on.
- R10: `stat_out_n` is always the inverse of `stat_out`.
- R11: Entering idle silences the status without waiting for a strobe. After re-enabling, the status stays off until the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hb_in | input | 1 | Incoming heartbeat enable clock |
| ret_in | input | 1 | Status clock returned from the stage below |
| uv_flag | input | 1 | Cell undervoltage seen in this measurement cycle |
| ov_flag | input | 1 | Cell overvoltage seen in this measurement cycle |
| tlow_flag | input | 1 | Temperature input at or below half the reference |
| meas_done | input | 1 | One-cycle end-of-measurement strobe |
| hb_out | output | 1 | Heartbeat forwarded to the stage below |
| stat_out | output | 1 | Status clock, true phase |
| stat_out_n | output | 1 | Status clock, complement |
| idle | output | 1 | Stage is in low-power idle |

## Verification
The bench builds the block with PMIN=16 and PMAX=80, so the whole enable window spans a few dozen system clocks. This keeps qualification, glitch tolerance, timeout and the too-slow case each within a few hundred cycles. A nominal 40-cycle heartbeat gives a matching tolerance of 5 cycles. The even-period returned clocks of 44 and 46 cycles therefore land on either side of the match boundary, and the 36-cycle case sits inside it.

// File: rtl/hb_chain_stage.sv
module hb_chain_stage #(
  parameter int PMIN    = 400,
  parameter int PMAX    = 8000,
  parameter int QUAL_N  = 3,
  parameter int DROP_N  = 2,
  parameter int MATCH_N = 2,
  parameter int SYNC    = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hb_in,
  input  logic ret_in,
  input  logic uv_flag,
  input  logic ov_flag,
  input  logic tlow_flag,
  input  logic meas_done,
  output logic hb_out,
  output logic stat_out,
  output logic stat_out_n,
  output logic idle
);

  localparam int CW = $clog2(PMAX + 2);
  localparam int QW = $clog2(QUAL_N + 1);
  localparam int DW = $clog2(DROP_N + 1);
  localparam int MW = $clog2(MATCH_N + 1);
  localparam logic [CW-1:0] MAXP1 = CW'(PMAX + 1);
  localparam logic [CW-1:0] LO    = CW'(PMIN);
  localparam logic [CW-1:0] HI    = CW'(PMAX);

  logic [SYNC:0]   hb_sh, ret_sh;
  logic            hb_s, hb_rise, ret_rise;
  logic [CW-1:0]   e_cnt, r_cnt, ref_per, r_diff;
  logic            e_seen, r_seen, e_ok, r_ok;
  logic [QW-1:0]   good;
  logic [DW-1:0]   bad;
  logic [MW-1:0]   mcnt;
  logic            enabled, match_q, gate, hb_q, stat_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      hb_sh  <= '0;
      ret_sh <= '0;
    end else begin
      hb_sh  <= {hb_sh[SYNC-1:0], hb_in};
      ret_sh <= {ret_sh[SYNC-1:0], ret_in};
    end

  assign hb_s     = hb_sh[SYNC-1];
  assign hb_rise  = hb_sh[SYNC-1] & ~hb_sh[SYNC];
  assign ret_rise = ret_sh[SYNC-1] & ~ret_sh[SYNC];

  // period counters saturate one past the window
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      e_cnt  <= MAXP1;
      e_seen <= 1'b0;
    end else if (hb_rise) begin
      e_cnt  <= CW'(1);
      e_seen <= 1'b1;
    end else if (e_cnt != MAXP1) begin
      e_cnt  <= e_cnt + CW'(1);
    end else begin
      e_seen <= 1'b0;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      r_cnt  <= MAXP1;
      r_seen <= 1'b0;
    end else if (ret_rise) begin
      r_cnt  <= CW'(1);
      r_seen <= 1'b1;
    end else if (r_cnt != MAXP1) begin
      r_cnt  <= r_cnt + CW'(1);
    end else begin
      r_seen <= 1'b0;
    end

  assign e_ok   = e_seen && (e_cnt >= LO) && (e_cnt <= HI);
  assign r_diff = (r_cnt >= ref_per) ? r_cnt - ref_per : ref_per - r_cnt;
  assign r_ok   = r_seen && (r_diff <= (ref_per >> 3));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      enabled <= 1'b0;
      good    <= '0;
      bad     <= '0;
      ref_per <= HI;
    end else if (e_cnt == MAXP1) begin
      enabled <= 1'b0;
      good    <= '0;
      bad     <= '0;
    end else if (hb_rise && e_seen) begin
      if (e_ok) begin
        ref_per <= e_cnt;
        bad     <= '0;
        if (good != QW'(QUAL_N)) good <= good + QW'(1);
        if (good >= QW'(QUAL_N - 1)) enabled <= 1'b1;
      end else begin
        good <= '0;
        if (bad != DW'(DROP_N)) bad <= bad + DW'(1);
        if (bad >= DW'(DROP_N - 1)) enabled <= 1'b0;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      match_q <= 1'b0;
      mcnt    <= '0;
    end else if (!enabled || r_cnt == MAXP1) begin
      match_q <= 1'b0;
      mcnt    <= '0;
    end else if (ret_rise && r_seen) begin
      if (r_ok) begin
        if (mcnt != MW'(MATCH_N)) mcnt <= mcnt + MW'(1);
        if (mcnt >= MW'(MATCH_N - 1)) match_q <= 1'b1;
      end else begin
        mcnt    <= '0;
        match_q <= 1'b0;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)
      gate <= 1'b0;
    else if (!enabled)
      gate <= 1'b0;
    else if (meas_done)
      gate <= match_q & ~uv_flag & ~ov_flag & ~tlow_flag;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      hb_q   <= 1'b0;
      stat_q <= 1'b0;
    end else begin
      hb_q   <= enabled & hb_s;
      stat_q <= gate & hb_s;
    end

  assign hb_out     = hb_q;
  assign stat_out   = stat_q;
  assign stat_out_n = ~stat_q;
  assign idle       = ~enabled;

  a_r2_enable_after_run: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(idle) |-> ($past(hb_rise) && $past(good) >= QW'(QUAL_N - 1)));

  a_r3_drop_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(idle) |-> ($past(bad) >= DW'(DROP_N - 1) || $past(e_cnt) == MAXP1));

  a_r4_silence_idles: assert property (@(posedge clk) disable iff (!rst_n)
    (e_cnt == MAXP1) |=> idle);

  a_r6_gate_needs_match: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate) |-> $past(match_q));

  a_r7_gate_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate) |-> $past(meas_done));

  a_r11_idle_kills_gate: assert property (@(posedge clk) disable iff (!rst_n)
    idle |=> !gate);

endmodule

// File: tb/hb_chain_stage_test.sv
module hb_chain_stage_test;
  logic clk = 0;
  logic rst_n = 0;
  logic hb_in = 0, ret_gen = 0, ret_loop = 1;
  logic uv = 0, ov = 0, tl = 0, meas = 0;
  logic hb_out, stat_out, stat_out_n, idle;
  int   hb_half = 0, ret_half = 0;
  int   errors = 0, checks = 0;
  bit   done = 0;

  wire ret_in = ret_loop ? hb_out : ret_gen;

  hb_chain_stage #(.PMIN(16), .PMAX(80)) uut (
    .clk(clk), .rst_n(rst_n), .hb_in(hb_in), .ret_in(ret_in),
    .uv_flag(uv), .ov_flag(ov), .tlow_flag(tl), .meas_done(meas),
    .hb_out(hb_out), .stat_out(stat_out), .stat_out_n(stat_out_n), .idle(idle));

  always #5 clk = ~clk;

  always begin
    @(posedge clk);
    if (hb_half == 0) #1 hb_in = 0;
    else begin
      repeat (hb_half - 1) @(posedge clk);
      #1 hb_in = ~hb_in;
    end
  end

  always begin
    @(posedge clk);
    if (ret_half == 0) #1 ret_gen = 0;
    else begin
      repeat (ret_half - 1) @(posedge clk);
      #1 ret_gen = ~ret_gen;
    end
  end

  task automatic chk(input bit ok, input string msg);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s", msg);
    end
  endtask

  task automatic strobe();
    @(posedge clk); #1 meas = 1;
    @(posedge clk); #1 meas = 0;
    repeat (6) @(posedge clk);
  endtask

  task automatic echo(input string tag, input bit on, input int n);
    int bad = 0, tog = 0, inv = 0;
    logic prev;
    @(negedge clk);
    prev = stat_out;
    repeat (n) begin
      @(negedge clk);
      if (stat_out_n !== ~stat_out) inv++;
      if (on) begin
        if (stat_out !== hb_out) bad++;
        if (stat_out !== prev) tog++;
      end else if (stat_out !== 1'b0) bad++;
      prev = stat_out;
    end
    chk(bad == 0 && (!on || tog >= 2),
        $sformatf("%s status %s: mismatches=%0d toggles=%0d, expected mismatches=0 toggles%s",
                  tag, on ? "echo" : "off", bad, tog, on ? ">=2" : " any"));
    chk(inv == 0, $sformatf("R10 complement broken on %0d samples, expected 0", inv));
  endtask

  task automatic idle_hold(input string tag, input logic val, input int n);
    int bad = 0;
    repeat (n) begin
      @(negedge clk);
      if (idle !== val) bad++;
    end
    chk(bad == 0, $sformatf("%s idle differed from %0b on %0d samples, expected 0", tag, val, bad));
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk(hb_out === 0 && stat_out === 0 && stat_out_n === 1 && idle === 1,
        $sformatf("R1 reset: hb_out=%b stat=%b stat_n=%b idle=%b, expected 0 0 1 1",
                  hb_out, stat_out, stat_out_n, idle));
    @(posedge clk); #1 rst_n = 1;
    repeat (4) @(negedge clk);
    chk(hb_out === 0 && stat_out === 0 && stat_out_n === 1 && idle === 1,
        $sformatf("R1 after reset: hb_out=%b stat=%b stat_n=%b idle=%b, expected 0 0 1 1",
                  hb_out, stat_out, stat_out_n, idle));
  endtask

  task automatic t_enable();
    int bad = 0;
    logic h0, h1, h2;
    ret_loop = 1;
    hb_half = 20;
    repeat (3) @(posedge hb_in);
    repeat (8) @(posedge clk);
    @(negedge clk);
    chk(idle === 1, $sformatf("R2 two good periods: idle=%b, expected 1", idle));
    @(posedge hb_in);
    repeat (8) @(posedge clk);
    @(negedge clk);
    chk(idle === 0, $sformatf("R2 three good periods: idle=%b, expected 0", idle));
    @(negedge clk); h2 = hb_in;
    @(negedge clk); h1 = hb_in;
    @(negedge clk); h0 = hb_in;
    repeat (200) begin
      @(negedge clk);
      if (hb_out !== h2) bad++;
      h2 = h1; h1 = h0; h0 = hb_in;
    end
    chk(bad == 0, $sformatf("R5 hb_out vs hb_in delayed 3: %0d mismatches, expected 0", bad));
    repeat (100) @(posedge clk);
    echo("R11 before first strobe", 0, 60);
    strobe();
    echo("R7 healthy", 1, 200);
  endtask

  task automatic t_strobe_timing();
    @(posedge clk); #1 uv = 1;
    echo("R7 uv pending, no strobe", 1, 120);
    strobe();
    echo("R9 uv at strobe", 0, 120);
    @(posedge clk); #1 uv = 0;
    echo("R7 uv cleared, no strobe", 0, 120);
    strobe();
    echo("R7 recovered at strobe", 1, 120);
    @(posedge clk); #1 ov = 1;
    repeat (30) @(posedge clk);
    #1 ov = 0;
    strobe();
    echo("R8 ov pulse between strobes", 1, 120);
  endtask

  task automatic t_faults();
    @(posedge clk); #1 ov = 1;
    strobe();
    echo("R9 ov at strobe", 0, 100);
    @(posedge clk); #1 ov = 0;
    strobe();
    echo("R9 ov cleared", 1, 100);
    @(posedge clk); #1 tl = 1;
    strobe();
    echo("R9 temp low at strobe", 0, 100);
    @(posedge clk); #1 tl = 0;
    strobe();
    echo("R9 temp cleared", 1, 100);
  endtask

  task automatic t_match();
    ret_half = 15; ret_loop = 0;
    repeat (200) @(posedge clk);
    strobe();
    echo("R6 return period 30", 0, 120);
    chk(idle === 0, $sformatf("R6 mismatch keeps stage enabled: idle=%b, expected 0", idle));
    ret_half = 22;
    repeat (200) @(posedge clk);
    strobe();
    echo("R6 return period 44", 1, 150);
    ret_half = 23;
    repeat (200) @(posedge clk);
    strobe();
    echo("R6 return period 46", 0, 150);
    ret_half = 18;
    repeat (200) @(posedge clk);
    strobe();
    echo("R6 return period 36", 1, 150);
    ret_loop = 1;
    repeat (200) @(posedge clk);
    strobe();
  endtask

  task automatic t_window();
    int bad = 0;
    @(posedge hb_in); hb_half = 4;
    @(posedge hb_in); hb_half = 20;
    idle_hold("R3 single short period", 0, 150);
    hb_half = 5;
    repeat (80) @(posedge clk);
    @(negedge clk);
    chk(idle === 1, $sformatf("R3 two short periods: idle=%b, expected 1", idle));
    repeat (60) begin
      @(negedge clk);
      if (hb_out !== 0) bad++;
    end
    chk(bad == 0, $sformatf("R5 hb_out while idle: %0d high samples, expected 0", bad));
    echo("R11 idle silences status", 0, 60);
    hb_half = 20;
    repeat (400) @(posedge clk);
    chk(idle === 0, $sformatf("R2 re-enable: idle=%b, expected 0", idle));
    echo("R11 no strobe after re-enable", 0, 100);
    strobe();
    echo("R11 strobe after re-enable", 1, 120);
  endtask

  task automatic t_timeout();
    hb_half = 0;
    repeat (130) @(posedge clk);
    @(negedge clk);
    chk(idle === 1 && hb_out === 0,
        $sformatf("R4 silent heartbeat: idle=%b hb_out=%b, expected 1 0", idle, hb_out));
    hb_half = 60;
    idle_hold("R4 heartbeat period 120", 1, 700);
    echo("R4 status with slow heartbeat", 0, 60);
  endtask

  initial begin
    #(10 * 60000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_enable();
    t_strobe_timing();
    t_faults();
    t_match();
    t_window();
    t_timeout();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule